// File: doc/BRIEF.md
# Read Turnaround and Receive Watchdog Controller

This block sequences the low-power read path of a serial display link controller. When the transmit side reports that a packet has finished and marks it as one that expects an answer from the panel (a read request, or a write that enables tearing reports), the block waits a programmable stop-holding interval. It then asks the physical layer to reverse the link direction. It holds that request until the physical layer acknowledges it, and after that watches the receive phase until receive data becomes valid.

Every timer advances only on a single-cycle escape-clock tick that is supplied from outside. Two watchdogs guard the read path. The turnaround watchdog runs from the request until the acknowledge. The receive watchdog counts only while the physical layer reports low-power receive mode and receive valid is still low. If a watchdog runs out, the block sets a sticky error flag, pulses an error interrupt and goes back to idle. A successful read produces a one-cycle ready pulse instead. While a transaction is in flight the block reports busy and ignores any new packet-done strobe.

Top module: `lpr_turnaround_ctrl`

## Requirements
- R1: After reset the block is idle: busy, ta_req, rd_ready and irq_err are 0, and both error flags are 0.
- R2: A pkt_done strobe in idle starts a transaction only when pkt_needs_ta is 1. With pkt_needs_ta at 0 the block stays idle, and busy remains 0 on the following cycle.
- R3: hold_cnt is sampled on the accepting pkt_done. After that, ta_req rises only once that many esc_tick pulses have been counted: the cycle after the count is at zero (for a value of 0, on the second cycle after acceptance).
- R4: ta_req stays 1 until ta_ack is seen. ta_ack then moves the block into the receive phase, and ta_ack takes priority over a turnaround timeout in the same cycle. ta_req is never 1 unless busy is 1.
- R5: ta_limit is sampled when ta_req rises. If ta_limit esc_tick pulses pass without ta_ack, ta_err (sticky) is set and irq_err pulses for one cycle. Both appear on the cycle after the expiry, and the block returns to idle.
- R6: rx_limit is sampled on ta_ack. The receive watchdog counts esc_tick pulses only while rx_lp_mode is 1. When it expires without rx_valid, rx_err (sticky) is set and irq_err pulses for one cycle. While rx_lp_mode is 0 the block waits in the receive phase with no time limit.
- R7: rx_valid during the receive phase ends the transaction. It gives a one-cycle rd_ready pulse on the next cycle, together with the return to idle. rd_ready and irq_err are never 1 together.
- R8: busy is 1 from the cycle after an accepted pkt_done until the transaction ends. A pkt_done seen while busy is ignored.
- R9: err_clr is a write-one-to-clear strobe: bit 0 clears ta_err and bit 1 clears rx_err. A set in the same cycle wins over the clear. Without a clear, a set flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_tick | input | 1 | One-cycle escape-clock tick that advances all timers |
| pkt_done | input | 1 | Strobe: a transmit packet has completed |
| pkt_needs_ta | input | 1 | Qualifies pkt_done: the packet expects a turnaround |
| hold_cnt | input | 16 | Stop-holding interval in ticks |
| ta_limit | input | 8 | Turnaround watchdog limit in ticks |
| rx_limit | input | 16 | Receive watchdog limit in ticks |
| ta_ack | input | 1 | Physical layer reports that the direction change is done |
| rx_valid | input | 1 | Physical layer receive data valid |
| rx_lp_mode | input | 1 | Physical layer is in low-power receive mode |
| err_clr | input | 2 | Write-one-to-clear strobes: bit 0 ta_err, bit 1 rx_err |
| busy | output | 1 | A transaction is in progress |
| ta_req | output | 1 | Turnaround request to the physical layer |
| rd_ready | output | 1 | One-cycle pulse: read data has arrived |
| irq_err | output | 1 | One-cycle pulse: a watchdog has expired |
| ta_err | output | 1 | Sticky turnaround timeout flag |
| rx_err | output | 1 | Sticky receive timeout flag |

## Verification
The checker tests several properties on every clock:
- ta_req is only raised while busy.
- An unqualified strobe leaves the block idle.
- The ready and error pulses never coincide.
- A ready pulse always lands in idle.
- An acknowledge drops the request on the next cycle.
- Every error pulse comes with a sticky flag.
- A flag stays set until its clear bit is written.

The exact tick counts of the hold interval and of both watchdogs, the rule that the receive watchdog pauses outside low-power receive mode, and acknowledge priority at a zero limit can only be shown by the bench's scenarios checked against its cycle model.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_TURN = 2'd2,
      ST_RECV = 2'd3
   } lpr_state_e;

   localparam int unsigned ERR_TA = 0;
   localparam int unsigned ERR_RX = 1;
   localparam int unsigned ERR_N  = 2;
endpackage

// File: rtl/lpr_down_timer.sv
module lpr_down_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpr_sticky_flag.sv
module lpr_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else if (set)
         q <= 1'b1;
      else if (clr)
         q <= 1'b0;
   end
endmodule

// File: rtl/lpr_seq_fsm.sv
module lpr_seq_fsm
   import lpr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             esc_tick,
   input  logic             start,
   input  logic             ta_ack,
   input  logic             rx_valid,
   input  logic             rx_lp_mode,
   input  logic             t_zero,
   output logic             ld_hold,
   output logic             ld_turn,
   output logic             ld_recv,
   output logic             t_dec,
   output logic             ta_expire,
   output logic             rx_expire,
   output logic             rx_got,
   output lpr_state_e       state
);
   lpr_state_e st_q, st_d;

   always_comb begin
      st_d      = st_q;
      ld_hold   = 1'b0;
      ld_turn   = 1'b0;
      ld_recv   = 1'b0;
      t_dec     = 1'b0;
      ta_expire = 1'b0;
      rx_expire = 1'b0;
      rx_got    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_d    = ST_HOLD;
               ld_hold = 1'b1;
            end
         end
         ST_HOLD: begin
            if (t_zero) begin
               st_d    = ST_TURN;
               ld_turn = 1'b1;
            end else begin
               t_dec = esc_tick;
            end
         end
         ST_TURN: begin
            if (ta_ack) begin
               st_d    = ST_RECV;
               ld_recv = 1'b1;
            end else if (t_zero) begin
               st_d      = ST_IDLE;
               ta_expire = 1'b1;
            end else begin
               t_dec = esc_tick;
            end
         end
         ST_RECV: begin
            if (rx_valid) begin
               st_d   = ST_IDLE;
               rx_got = 1'b1;
            end else if (rx_lp_mode) begin
               if (t_zero) begin
                  st_d      = ST_IDLE;
                  rx_expire = 1'b1;
               end else begin
                  t_dec = esc_tick;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else
         st_q <= st_d;
   end

   assign state = st_q;
endmodule

// File: rtl/lpr_turnaround_ctrl.sv
module lpr_turnaround_ctrl
   import lpr_pkg::*;
#(
   parameter int unsigned HOLD_W = 16,
   parameter int unsigned TA_W   = 8,
   parameter int unsigned RX_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              esc_tick,
   input  logic              pkt_done,
   input  logic              pkt_needs_ta,
   input  logic [HOLD_W-1:0] hold_cnt,
   input  logic [TA_W-1:0]   ta_limit,
   input  logic [RX_W-1:0]   rx_limit,
   input  logic              ta_ack,
   input  logic              rx_valid,
   input  logic              rx_lp_mode,
   input  logic [ERR_N-1:0]  err_clr,
   output logic              busy,
   output logic              ta_req,
   output logic              rd_ready,
   output logic              irq_err,
   output logic              ta_err,
   output logic              rx_err
);
   localparam int unsigned W_HT  = (HOLD_W > TA_W) ? HOLD_W : TA_W;
   localparam int unsigned CNT_W = (W_HT > RX_W) ? W_HT : RX_W;

   generate
      if (HOLD_W < 1 || TA_W < 1 || RX_W < 1) begin : g_bad_width
         $error("lpr_turnaround_ctrl: timer widths must be at least 1");
      end
      if (CNT_W > 32) begin : g_too_wide
         $error("lpr_turnaround_ctrl: timer width above 32 bits");
      end
   endgenerate

   lpr_state_e   state;
   logic         start, t_zero, t_dec;
   logic         ld_hold, ld_turn, ld_recv;
   logic         ta_expire, rx_expire, rx_got;
   logic         t_load;
   logic [CNT_W-1:0] t_val;
   logic [ERR_N-1:0] err_set, err_q;
   logic         rdy_q, irq_q;

   assign start = pkt_done && pkt_needs_ta;

   lpr_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .esc_tick   (esc_tick),
      .start      (start),
      .ta_ack     (ta_ack),
      .rx_valid   (rx_valid),
      .rx_lp_mode (rx_lp_mode),
      .t_zero     (t_zero),
      .ld_hold    (ld_hold),
      .ld_turn    (ld_turn),
      .ld_recv    (ld_recv),
      .t_dec      (t_dec),
      .ta_expire  (ta_expire),
      .rx_expire  (rx_expire),
      .rx_got     (rx_got),
      .state      (state)
   );

   always_comb begin
      t_val = '0;
      if (ld_hold)
         t_val[HOLD_W-1:0] = hold_cnt;
      else if (ld_turn)
         t_val[TA_W-1:0] = ta_limit;
      else if (ld_recv)
         t_val[RX_W-1:0] = rx_limit;
   end
   assign t_load = ld_hold | ld_turn | ld_recv;

   lpr_down_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .dec      (t_dec),
      .zero     (t_zero)
   );

   assign err_set[ERR_TA] = ta_expire;
   assign err_set[ERR_RX] = rx_expire;

   generate
      for (genvar i = 0; i < ERR_N; i++) begin : g_err
         lpr_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (err_set[i]),
            .clr   (err_clr[i]),
            .q     (err_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         rdy_q <= rx_got;
         irq_q <= |err_set;
      end
   end

   assign busy     = (state != ST_IDLE);
   assign ta_req   = (state == ST_TURN);
   assign rd_ready = rdy_q;
   assign irq_err  = irq_q;
   assign ta_err   = err_q[ERR_TA];
   assign rx_err   = err_q[ERR_RX];
endmodule

// File: rtl/lpr_turnaround_chk.sv
module lpr_turnaround_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pkt_done,
   input logic       pkt_needs_ta,
   input logic       ta_ack,
   input logic [1:0] err_clr,
   input logic       busy,
   input logic       ta_req,
   input logic       rd_ready,
   input logic       irq_err,
   input logic       ta_err,
   input logic       rx_err
);
   assert_req_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ta_req |-> busy);

   assert_ack_drops_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ta_req && ta_ack) |=> !ta_req);

   assert_no_flag_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && pkt_done && !pkt_needs_ta) |=> !busy);

   assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_ready && irq_err));

   assert_ready_in_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> !busy);

   assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (ta_err || rx_err));

   assert_ta_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ta_err && !err_clr[0]) |=> ta_err);

   assert_rx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err && !err_clr[1]) |=> rx_err);
endmodule

bind lpr_turnaround_ctrl lpr_turnaround_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pkt_done     (pkt_done),
   .pkt_needs_ta (pkt_needs_ta),
   .ta_ack       (ta_ack),
   .err_clr      (err_clr),
   .busy         (busy),
   .ta_req       (ta_req),
   .rd_ready     (rd_ready),
   .irq_err      (irq_err),
   .ta_err       (ta_err),
   .rx_err       (rx_err)
);

// File: tb/tb_lpr_turnaround_ctrl.sv
`timescale 1ns/1ps
module tb_lpr_turnaround_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        esc_tick = 1'b0;
   logic        pkt_done = 1'b0;
   logic        pkt_needs_ta = 1'b0;
   logic [15:0] hold_cnt = '0;
   logic [7:0]  ta_limit = '0;
   logic [15:0] rx_limit = '0;
   logic        ta_ack = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_lp_mode = 1'b0;
   logic [1:0]  err_clr = '0;
   logic        busy, ta_req, rd_ready, irq_err, ta_err, rx_err;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   bit running = 1'b0;

   always #2.5 clk = ~clk;

   lpr_turnaround_ctrl dut (
      .clk(clk), .rst_n(rst_n), .esc_tick(esc_tick), .pkt_done(pkt_done),
      .pkt_needs_ta(pkt_needs_ta), .hold_cnt(hold_cnt), .ta_limit(ta_limit),
      .rx_limit(rx_limit), .ta_ack(ta_ack), .rx_valid(rx_valid),
      .rx_lp_mode(rx_lp_mode), .err_clr(err_clr), .busy(busy), .ta_req(ta_req),
      .rd_ready(rd_ready), .irq_err(irq_err), .ta_err(ta_err), .rx_err(rx_err)
   );

   // behavioural reference: phase 0 idle, 1 hold, 2 turnaround, 3 receive
   int m_phase = 0;
   int m_left = 0;
   bit m_ta_err = 0, m_rx_err = 0, m_rdy = 0, m_irq = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_left = 0; m_ta_err = 0; m_rx_err = 0; m_rdy = 0; m_irq = 0;
      end else begin
         bit set_ta, set_rx;
         set_ta = 0; set_rx = 0; m_rdy = 0;
         if (m_phase == 0) begin
            if (pkt_done && pkt_needs_ta) begin m_phase = 1; m_left = int'(hold_cnt); end
         end else if (m_phase == 1) begin
            if (m_left == 0) begin m_phase = 2; m_left = int'(ta_limit); end
            else if (esc_tick) m_left--;
         end else if (m_phase == 2) begin
            if (ta_ack) begin m_phase = 3; m_left = int'(rx_limit); end
            else if (m_left == 0) begin set_ta = 1; m_phase = 0; end
            else if (esc_tick) m_left--;
         end else begin
            if (rx_valid) begin m_rdy = 1; m_phase = 0; end
            else if (rx_lp_mode) begin
               if (m_left == 0) begin set_rx = 1; m_phase = 0; end
               else if (esc_tick) m_left--;
            end
         end
         m_irq = set_ta | set_rx;
         m_ta_err = set_ta | (m_ta_err & !err_clr[0]);
         m_rx_err = set_rx | (m_rx_err & !err_clr[1]);
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         chk("R8", "busy", int'(busy), int'(m_phase != 0));
         chk("R4", "ta_req", int'(ta_req), int'(m_phase == 2));
         chk("R7", "rd_ready", int'(rd_ready), int'(m_rdy));
         chk("R5", "irq_err", int'(irq_err), int'(m_irq));
         chk("R5", "ta_err", int'(ta_err), int'(m_ta_err));
         chk("R6", "rx_err", int'(rx_err), int'(m_rx_err));
      end
   end

   // escape tick: one cycle in every four
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         esc_tick = 1'b1;
         @(negedge clk);
         esc_tick = 1'b0;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_pkt(input bit need, input int hold);
      hold_cnt = 16'(hold);
      pkt_needs_ta = need;
      pkt_done = 1'b1;
      cyc(1);
      pkt_done = 1'b0;
      pkt_needs_ta = 1'b0;
   endtask

   task automatic wait_req(input int maxc);
      for (int i = 0; i < maxc && !ta_req; i++) cyc(1);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      running = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "ta_req after reset", int'(ta_req), 0);
      chk("R1", "flags after reset", int'(ta_err | rx_err | irq_err | rd_ready), 0);

      // R2 unqualified packet ignored
      send_pkt(1'b0, 5);
      chk("R2", "busy after plain packet", int'(busy), 0);

      // R3 hold then normal read
      ta_limit = 8'd20;
      rx_limit = 16'd50;
      send_pkt(1'b1, 3);
      hold_cnt = 16'd200;  // R3: later change must not matter
      chk("R3", "no request during hold", int'(ta_req), 0);
      chk("R8", "busy in hold", int'(busy), 1);
      // R8 strobe while busy is ignored
      send_pkt(1'b1, 0);
      wait_req(40);
      chk("R3", "request after hold", int'(ta_req), 1);
      cyc(3);
      chk("R4", "request held without ack", int'(ta_req), 1);
      ta_ack = 1'b1; cyc(1); ta_ack = 1'b0;
      chk("R4", "request dropped on ack", int'(ta_req), 0);
      cyc(6);
      rx_lp_mode = 1'b1;
      cyc(8);
      rx_valid = 1'b1; cyc(1); rx_valid = 1'b0; rx_lp_mode = 1'b0;
      chk("R7", "ready pulse", int'(rd_ready), 1);
      cyc(1);
      chk("R7", "ready pulse width", int'(rd_ready), 0);

      // R5 turnaround timeout
      ta_limit = 8'd2;
      send_pkt(1'b1, 0);
      cyc(20);
      chk("R5", "ta_err set", int'(ta_err), 1);
      chk("R5", "idle after timeout", int'(busy), 0);
      cyc(5);
      chk("R9", "ta_err sticky", int'(ta_err), 1);
      err_clr = 2'b01; cyc(1); err_clr = 2'b00;
      chk("R9", "ta_err cleared", int'(ta_err), 0);

      // R6 receive watchdog pauses outside low-power receive mode
      ta_limit = 8'd10;
      rx_limit = 16'd3;
      send_pkt(1'b1, 1);
      wait_req(20);
      ta_ack = 1'b1; cyc(1); ta_ack = 1'b0;
      cyc(30);
      chk("R6", "waiting without lp mode", int'(busy), 1);
      rx_lp_mode = 1'b1;
      cyc(25);
      rx_lp_mode = 1'b0;
      chk("R6", "rx_err set", int'(rx_err), 1);
      chk("R6", "idle after rx timeout", int'(busy), 0);
      err_clr = 2'b01; cyc(1); err_clr = 2'b00;
      chk("R9", "bit0 leaves rx_err", int'(rx_err), 1);
      err_clr = 2'b10; cyc(1); err_clr = 2'b00;
      chk("R9", "rx_err cleared", int'(rx_err), 0);

      // R4 ack beats a zero turnaround limit
      ta_limit = 8'd0;
      ta_ack = 1'b1;
      send_pkt(1'b1, 0);
      cyc(3);
      ta_ack = 1'b0;
      chk("R4", "ack wins at zero limit", int'(ta_err), 0);
      chk("R4", "in receive phase", int'(busy), 1);
      rx_valid = 1'b1; cyc(1); rx_valid = 1'b0;
      chk("R7", "ready after fast path", int'(rd_ready), 1);
      cyc(4);

      running = 1'b0;
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog run did not complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule